// File: doc/BRIEF.md
# Multi-Polynomial CRC Engine

A memory-mapped checksum accelerator on a plain single-cycle register bus. Software picks one of four generator polynomials (16-bit CCITT, 8-bit, 16-bit, 32-bit) and how many low bytes of each data write count (one, two or four). A running checksum register absorbs every enabled data write in the same clock cycle, so a stream of writes on back-to-back cycles runs at full bus rate.

Optional transforms sit on both sides of the shift logic. On the way in, the written word can be one's-complemented and have the bit order of each byte mirrored. On the way out, the checksum can be bit-mirrored across the polynomial width and one's-complemented. With these, one datapath covers both reflected and non-reflected CRC variants, and variants with or without a final inversion. Writing the initialization bit copies the seed into the checksum and starts a new message. Length and transform settings can be changed mid-message without disturbing the running value.

Top module: `crc_eng`

## Requirements
- R1: After reset the control register reads 0x00000000 and the seed register holds all ones. With the reset polynomial (16-bit CCITT) both the seed and the checksum read 0x0000FFFF.
- R2: Byte offsets are 0x0 control, 0x4 data, 0x8 seed and 0xC checksum. The data offset reads zero. A write to the checksum offset leaves the checksum unchanged.
- R3: When control bit 0 (enable) is clear, a data write leaves the checksum unchanged.
- R4: Writing control with bit 1 set loads the seed into the checksum on that edge. Bit 1 always reads back 0, and every other control bit reads back as written.
- R5: Control bits [31:30] select the polynomial: 00 = 0x1021 (16-bit), 01 = 0x07 (8-bit), 10 = 0x8005 (16-bit), 11 = 0x04C11DB7 (32-bit). Each polynomial is applied MSB-first.
- R6: Control bits [29:28] select the input width: 00 uses data[7:0], 01 uses data[15:0], 1x uses all 32 bits. Unused upper data bits have no effect. Valid bytes are folded highest first.
- R7: Control bit 24 mirrors the bit order inside each byte of the written data, so 0xAABBCCDD is processed as 0x55DD33BB.
- R8: Control bit 26 one's-complements the written data before the per-byte mirror.
- R9: Control bit 25 mirrors the checksum as read across the polynomial width. In 32-bit mode 0xDD7B0F2E reads as 0x74F0DEBB. In 8-bit mode 0x01 reads as 0x80.
- R10: Control bit 27 one's-complements the checksum as read, within the polynomial width only.
- R11: Seed and checksum reads return zero above the polynomial width.
- R12: Data writes on consecutive cycles each fold into the checksum without a gap. The checksum changes only on an enabled data write or an initialization.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Bus access this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the same cycle as a read |

## Verification
The hardest case to reach from the ports is a message whose width setting changes partway through. Proving that the engine folds bytes highest-first and ignores unused upper bits requires a known result that only comes out right when both rules hold. The bench feeds the nine-character ASCII digit string as words or halfwords, then switches to byte width for the last character, and puts junk in the unused upper bits. It compares the result with published catalog checksums for eleven polynomial, reflection and inversion combinations. The input complement and the per-byte mirror are each checked by two runs that should give the same checksum: one with the transform enabled, and one with the transform applied by hand to the data.

// File: rtl/crc_eng_pkg.sv
package crc_eng_pkg;
  localparam int REG_W     = 32;
  localparam int NUM_MODES = 4;
  localparam int OFS_CTRL  = 'h0;
  localparam int OFS_DATA  = 'h4;
  localparam int OFS_SEED  = 'h8;
  localparam int OFS_CHK   = 'hC;

  typedef enum logic [1:0] {
    MODE_CCITT = 2'b00,
    MODE_C8    = 2'b01,
    MODE_C16   = 2'b10,
    MODE_C32   = 2'b11
  } crc_mode_e;

  typedef enum logic [1:0] {
    LEN_B8   = 2'b00,
    LEN_B16  = 2'b01,
    LEN_B32  = 2'b10,
    LEN_B32X = 2'b11
  } crc_len_e;

  typedef struct packed {
    crc_mode_e   mode;
    crc_len_e    len;
    logic        out_cpl;
    logic        in_cpl;
    logic        out_rev;
    logic        in_rev;
    logic [21:0] spare;
    logic        init;
    logic        en;
  } crc_ctl_t;

  function automatic int mode_width(int m);
    case (m)
      1:       return 8;
      3:       return 32;
      default: return 16;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] mode_poly(int m);
    case (m)
      0:       return 32'h0000_1021;
      1:       return 32'h0000_0007;
      2:       return 32'h0000_8005;
      default: return 32'h04C1_1DB7;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] width_mask(crc_mode_e m);
    case (m)
      MODE_C8:  return 32'h0000_00FF;
      MODE_C32: return 32'hFFFF_FFFF;
      default:  return 32'h0000_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/crc_eng_regs.sv
module crc_eng_regs
  import crc_eng_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [REG_W-1:0]  bus_wdata_i,
  input  logic [REG_W-1:0]  fold_i,
  input  logic [REG_W-1:0]  chk_view_i,
  output crc_ctl_t          ctl_o,
  output logic [REG_W-1:0]  chk_o,
  output logic [REG_W-1:0]  bus_rdata_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] A_SEED = ADDR_W'(OFS_SEED);
  localparam logic [ADDR_W-1:0] A_CHK  = ADDR_W'(OFS_CHK);

  crc_ctl_t         ctl_q;
  logic [REG_W-1:0] seed_q;
  logic [REG_W-1:0] chk_q;
  logic             wr;
  crc_ctl_t         ctl_wr;

  assign wr = bus_valid_i && bus_write_i;

  always_comb begin
    ctl_wr      = crc_ctl_t'(bus_wdata_i);
    ctl_wr.init = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= '0;
      seed_q <= '1;
      chk_q  <= '1;
    end else if (wr) begin
      case (bus_addr_i)
        A_CTRL: begin
          ctl_q <= ctl_wr;
          if (bus_wdata_i[1]) chk_q <= seed_q;
        end
        A_DATA: if (ctl_q.en) chk_q <= fold_i;
        A_SEED: seed_q <= bus_wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_valid_i && !bus_write_i) begin
      case (bus_addr_i)
        A_CTRL:  bus_rdata_o = ctl_q;
        A_SEED:  bus_rdata_o = seed_q & width_mask(ctl_q.mode);
        A_CHK:   bus_rdata_o = chk_view_i;
        default: bus_rdata_o = '0;
      endcase
    end
  end

  assign ctl_o = ctl_q;
  assign chk_o = chk_q;

  p_ro_checksum_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && bus_addr_i == A_CHK) |=> $stable(chk_q));

  p_hold_when_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && bus_addr_i == A_DATA && !ctl_q.en) |=> $stable(chk_q));

  p_init_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && bus_addr_i == A_CTRL && bus_wdata_i[1]) |=> (chk_q == $past(seed_q)));

  p_quiet_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && (bus_addr_i == A_CTRL || bus_addr_i == A_DATA)) |=> $stable(chk_q));
endmodule

// File: rtl/crc_eng_in_xform.sv
module crc_eng_in_xform
  import crc_eng_pkg::*;
(
  input  logic [REG_W-1:0] data_i,
  input  logic             cpl_i,
  input  logic             rev_i,
  output logic [REG_W-1:0] data_o
);
  localparam int NBYTES = REG_W / 8;

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    logic [7:0] inv;
    logic [7:0] mir;
    assign inv = data_i[8*i +: 8] ^ {8{cpl_i}};
    always_comb begin
      for (int k = 0; k < 8; k++) mir[k] = inv[7-k];
    end
    assign data_o[8*i +: 8] = rev_i ? mir : inv;
  end
endmodule

// File: rtl/crc_eng_core.sv
module crc_eng_core
  import crc_eng_pkg::*;
(
  input  logic [REG_W-1:0] chk_i,
  input  logic [REG_W-1:0] data_i,
  input  logic [2:0]       nbytes_i,
  input  crc_mode_e        mode_i,
  output logic [REG_W-1:0] fold_o
);
  localparam int NBYTES = REG_W / 8;

  logic [NUM_MODES-1:0][REG_W-1:0] lanes;

  for (genvar m = 0; m < NUM_MODES; m++) begin : g_lane
    localparam int           W = mode_width(m);
    localparam logic [W-1:0] P = W'(mode_poly(m));
    logic [W-1:0] acc;
    always_comb begin
      acc = chk_i[W-1:0];
      for (int b = NBYTES - 1; b >= 0; b--) begin
        if (b < int'(nbytes_i)) begin
          for (int k = 7; k >= 0; k--) begin
            acc = {acc[W-2:0], 1'b0} ^ ({W{acc[W-1] ^ data_i[8*b+k]}} & P);
          end
        end
      end
    end
    assign lanes[m] = REG_W'(acc);
  end

  assign fold_o = lanes[mode_i];
endmodule

// File: rtl/crc_eng_out_xform.sv
module crc_eng_out_xform
  import crc_eng_pkg::*;
(
  input  logic [REG_W-1:0] chk_i,
  input  crc_mode_e        mode_i,
  input  logic             rev_i,
  input  logic             cpl_i,
  output logic [REG_W-1:0] view_o
);
  logic [NUM_MODES-1:0][REG_W-1:0] lanes;

  for (genvar m = 0; m < NUM_MODES; m++) begin : g_lane
    localparam int W = mode_width(m);
    logic [W-1:0] mir;
    logic [W-1:0] sel;
    always_comb begin
      for (int k = 0; k < W; k++) mir[k] = chk_i[W-1-k];
    end
    assign sel      = (rev_i ? mir : chk_i[W-1:0]) ^ {W{cpl_i}};
    assign lanes[m] = REG_W'(sel);
  end

  assign view_o = lanes[mode_i];
endmodule

// File: rtl/crc_eng.sv
module crc_eng
  import crc_eng_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o
);
  crc_ctl_t         ctl;
  logic [REG_W-1:0] chk;
  logic [REG_W-1:0] din_x;
  logic [REG_W-1:0] fold;
  logic [REG_W-1:0] view;
  logic [2:0]       nbytes;

  always_comb begin
    case (ctl.len)
      LEN_B8:  nbytes = 3'd1;
      LEN_B16: nbytes = 3'd2;
      default: nbytes = 3'd4;
    endcase
  end

  crc_eng_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_valid_i (bus_valid_i),
    .bus_write_i (bus_write_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .fold_i      (fold),
    .chk_view_i  (view),
    .ctl_o       (ctl),
    .chk_o       (chk),
    .bus_rdata_o (bus_rdata_o)
  );

  crc_eng_in_xform u_in_xform (
    .data_i (bus_wdata_i),
    .cpl_i  (ctl.in_cpl),
    .rev_i  (ctl.in_rev),
    .data_o (din_x)
  );

  crc_eng_core u_core (
    .chk_i    (chk),
    .data_i   (din_x),
    .nbytes_i (nbytes),
    .mode_i   (ctl.mode),
    .fold_o   (fold)
  );

  crc_eng_out_xform u_out_xform (
    .chk_i  (chk),
    .mode_i (ctl.mode),
    .rev_i  (ctl.out_rev),
    .cpl_i  (ctl.out_cpl),
    .view_o (view)
  );

  p_upper_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && !bus_write_i && ctl.mode == MODE_C8 &&
     (bus_addr_i == ADDR_W'(OFS_CHK) || bus_addr_i == ADDR_W'(OFS_SEED)))
    |-> (bus_rdata_o[31:8] == 24'd0));
endmodule

// File: tb/crc_eng_bench.sv
`timescale 1ns/1ps
module crc_eng_bench;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] A_DATA = 4'h4;
  localparam logic [ADDR_W-1:0] A_SEED = 4'h8;
  localparam logic [ADDR_W-1:0] A_CHK  = 4'hC;

  typedef struct packed {
    logic [31:0] ctl;
    logic [31:0] seed;
    logic        half;
    logic [31:0] expv;
  } vec_t;

  // catalog checks of the nine-digit ASCII string "123456789"
  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{32'hCB000001, 32'hFFFFFFFF, 1'b0, 32'hCBF43926},
    '{32'hC8000001, 32'hFFFFFFFF, 1'b1, 32'hFC891918},
    '{32'hC0000001, 32'hFFFFFFFF, 1'b0, 32'h0376E6E7},
    '{32'h00000001, 32'h0000FFFF, 1'b1, 32'h000029B1},
    '{32'h00000001, 32'h00000000, 1'b0, 32'h000031C3},
    '{32'h03000001, 32'h00000000, 1'b1, 32'h00002189},
    '{32'h83000001, 32'h00000000, 1'b0, 32'h0000BB3D},
    '{32'h80000001, 32'h00000000, 1'b1, 32'h0000FEE8},
    '{32'h40000001, 32'h00000000, 1'b0, 32'h000000F4},
    '{32'h8B000001, 32'h00000000, 1'b1, 32'h000044C2},
    '{32'h08000001, 32'hFFFFFFFF, 1'b0, 32'h0000D64E}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              valid = 1'b0;
  logic              write = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  int                total = 0;
  int                bad = 0;

  always #2 clk = ~clk;

  crc_eng #(.ADDR_W(ADDR_W)) u_crc_eng (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bus_valid_i (valid),
    .bus_write_i (write),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata)
  );

  function automatic logic [31:0] rev32(logic [31:0] v);
    logic [31:0] r;
    for (int k = 0; k < 32; k++) r[k] = v[31-k];
    return r;
  endfunction

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    valid = 1'b1; write = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    valid = 1'b0; write = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    valid = 1'b1; write = 1'b0; addr = a;
    #1 d = rdata;
    @(posedge clk); #1;
    valid = 1'b0;
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%08h exp=%08h", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got=timeout exp=finish");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v, a, b;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(A_CTRL, v); check("R1 ctrl", v, 32'h0);
    rd(A_SEED, v); check("R1 seed", v, 32'h0000FFFF);
    rd(A_CHK, v);  check("R1 checksum", v, 32'h0000FFFF);
    // R2 data reads zero, checksum read-only
    rd(A_DATA, v); check("R2 data read", v, 32'h0);
    wr(A_CHK, 32'h12345678);
    rd(A_CHK, v);  check("R2 checksum write ignored", v, 32'h0000FFFF);

    // R5 R6 R7 R9 R10 R12 table walk, back-to-back data writes
    for (int i = 0; i < NV; i++) begin
      wr(A_SEED, VECS[i].seed);
      if (VECS[i].half) begin
        wr(A_CTRL, VECS[i].ctl | 32'h1000_0002);
        wr(A_DATA, 32'hDEAD3132);
        wr(A_DATA, 32'hBEEF3334);
        wr(A_DATA, 32'h00003536);
        wr(A_DATA, 32'hFFFF3738);
        wr(A_CTRL, VECS[i].ctl);
        wr(A_DATA, 32'h12345639);
      end else begin
        wr(A_CTRL, VECS[i].ctl | 32'h2000_0002);
        wr(A_DATA, 32'h31323334);
        wr(A_DATA, 32'h35363738);
        wr(A_CTRL, VECS[i].ctl);
        wr(A_DATA, 32'hA5A5A539);
      end
      rd(A_CHK, v);
      check($sformatf("R5 R6 R12 vector %0d", i), v, VECS[i].expv);
    end

    // R4 init loads seed, self-clears, other bits kept
    wr(A_SEED, 32'hCAFEBABE);
    wr(A_CTRL, 32'hC300_0003);
    rd(A_CTRL, v); check("R4 ctrl readback", v, 32'hC300_0001);
    rd(A_CHK, v);  check("R4 seed loaded", v, rev32(32'hCAFEBABE));

    // R3 disabled engine ignores data
    wr(A_CTRL, 32'hC000_0000);
    wr(A_DATA, 32'h11111111);
    rd(A_CHK, v);  check("R3 disabled hold", v, 32'hCAFEBABE);

    // R9 output mirror, 32-bit and 8-bit
    wr(A_SEED, 32'hDD7B0F2E);
    wr(A_CTRL, 32'hC200_0003);
    rd(A_CHK, v);  check("R9 mirror 32", v, 32'h74F0DEBB);
    wr(A_SEED, 32'h00000001);
    wr(A_CTRL, 32'h4200_0003);
    rd(A_CHK, v);  check("R9 mirror 8", v, 32'h00000080);

    // R10 output complement limited to width
    wr(A_SEED, 32'h00001234);
    wr(A_CTRL, 32'h8800_0003);
    rd(A_CHK, v);  check("R10 complement 16", v, 32'h0000EDCB);

    // R11 upper bits read zero
    wr(A_SEED, 32'hABCDEF12);
    wr(A_CTRL, 32'h4000_0003);
    rd(A_SEED, v); check("R11 seed masked", v, 32'h00000012);
    rd(A_CHK, v);  check("R11 checksum masked", v, 32'h00000012);

    // R8 input complement equals complemented data
    wr(A_SEED, 32'hFFFFFFFF);
    wr(A_CTRL, 32'hE500_0003);
    wr(A_DATA, 32'h31323334);
    rd(A_CHK, a);
    wr(A_CTRL, 32'hE100_0003);
    wr(A_DATA, 32'hCECDCCCB);
    rd(A_CHK, b);
    check("R8 input complement", a, b);

    // R7 per-byte mirror equals hand-mirrored data
    wr(A_CTRL, 32'hE100_0003);
    wr(A_DATA, 32'hAABBCCDD);
    rd(A_CHK, a);
    wr(A_CTRL, 32'hE000_0003);
    wr(A_DATA, 32'h55DD33BB);
    rd(A_CHK, b);
    check("R7 byte mirror", a, b);

    summary();
    $finish;
  end
endmodule